// File: doc/BRIEF.md
# Triggered Capture Buffer Dumper

The block keeps a circular store of mixed-signal samples, each a 10-bit analog value plus 8 logic bits. While capturing, every valid sample goes into the store. Once the store holds a full window of samples, a trigger ends the capture. A forced capture ends it the same way, with no trigger needed. The captured window then waits for a host to read it.

The host works through three register addresses on a write-only command port. A write to the status address returns one status byte on the byte output. A write to the buffer address starts a dump of the whole window, oldest sample first. A falling edge of bit 3 at the control address requests a forced capture. Each sample is spread across three bytes, and each byte uses only its low six bits. The bytes leave through a valid/ready stream toward a serial transmitter. When the last byte has been taken, the block restarts capture on its own.

Top module: `capture_dumper`

## Requirements
- R1: After reset, `outValid` is low and a status query returns 0x01 (filling).
- R2: In capture, each cycle with `sampleValid` high stores one sample. Once DEPTH samples have been stored since capture began, a status query returns 0x02 (full, waiting).
- R3: While full, a high `trigIn` ends capture. A trigger before the store is full has no effect. Once capture has ended, the status is 0x05 (data ready) and later samples are not stored.
- R4: A control write (address 4) with bit 3 high, followed by one with bit 3 low, arms a forced capture. The forced capture ends capture as soon as the store is full, without `trigIn`.
- R5: A write to address 1 queues exactly one status byte. The query is ignored while a dump runs or while a status byte is still waiting.
- R6: A write to address 2 in the data-ready state starts a dump of exactly 3*DEPTH bytes (3072 by default). The request is ignored in any other state and while a status byte waits.
- R7: Byte 0 of a sample carries analog[5:0] in bits [5:0]. Byte 1 carries analog[9:6] in bits [3:0] and logic[1:0] in bits [5:4]. Byte 2 carries logic[7:2] in bits [5:0].
- R8: Bits 7 and 6 of every byte sent are zero.
- R9: A dump sends the last DEPTH stored samples oldest first, in byte order 0, 1, 2.
- R10: A byte is held on `outData` until `outReady` accepts it. After the last dump byte, capture restarts with an empty fill count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | A sample is present this cycle |
| analogIn | input | 10 | Analog part of the sample |
| logicIn | input | 8 | Logic part of the sample |
| trigIn | input | 1 | Trigger condition from the trigger unit |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address (1 status, 2 buffer, 4 control) |
| regData | input | 8 | Register write data |
| outValid | output | 1 | Byte available |
| outData | output | 8 | Status or sample byte |
| outReady | input | 1 | Transmitter accepts the byte |

## Verification
The capture path is driven with samples that have idle gaps and with a window longer than the store. This separates a correct circular oldest-first order from a dump that simply starts at address zero. The first dump runs against a ready pattern that stalls one cycle in three, so stalls are covered. The second dump runs with ready held high, which tests back-to-back transfers. Triggers sent before the store is full, along with dump and status requests sent in the wrong state, confirm that those requests have no effect. The forced-capture sequence is issued before the store is full, which shows that the request stays pending until enough samples are held.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  typedef enum logic [1:0] {ST_CAPTURE, ST_READY, ST_DUMP} capState_e;

  typedef struct packed {
    logic       memWr;
    logic [1:0] byteSel;
  } dpCtrl_t;

  localparam logic [3:0] ADDR_STATUS = 4'h1;
  localparam logic [3:0] ADDR_BUFFER = 4'h2;
  localparam logic [3:0] ADDR_CTRL   = 4'h4;
  localparam int         FORCE_BIT   = 3;

  localparam logic [7:0] STAT_FILLING = 8'h01;
  localparam logic [7:0] STAT_WAITING = 8'h02;
  localparam logic [7:0] STAT_READY   = 8'h05;

  localparam int ANALOG_W = 10;
  localparam int LOGIC_W  = 8;
  localparam int SAMPLE_W = ANALOG_W + LOGIC_W;
endpackage

// File: rtl/cbd_datapath.sv
module cbd_datapath
  import cbd_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  dpCtrl_t             ctl,
  input  logic [PTR_W-1:0]    wrAddr,
  input  logic [PTR_W-1:0]    rdAddr,
  input  logic [ANALOG_W-1:0] analogIn,
  input  logic [LOGIC_W-1:0]  logicIn,
  output logic [7:0]          dumpByte
);
  logic [SAMPLE_W-1:0] store [DEPTH];
  logic [SAMPLE_W-1:0] rdWord;
  logic [ANALOG_W-1:0] rdAnalog;
  logic [LOGIC_W-1:0]  rdLogic;

  always_ff @(posedge clk) begin
    if (ctl.memWr) store[wrAddr] <= {logicIn, analogIn};
  end

  assign rdWord   = store[rdAddr];
  assign rdAnalog = rdWord[ANALOG_W-1:0];
  assign rdLogic  = rdWord[SAMPLE_W-1:ANALOG_W];

  // three six-bit slices per sample, top two bits always zero
  always_comb begin
    case (ctl.byteSel)
      2'd0:    dumpByte = {2'b00, rdAnalog[5:0]};
      2'd1:    dumpByte = {2'b00, rdLogic[1:0], rdAnalog[9:6]};
      default: dumpByte = {2'b00, rdLogic[7:2]};
    endcase
  end
endmodule

// File: rtl/cbd_ctrl.sv
module cbd_ctrl
  import cbd_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sampleValid,
  input  logic             trigIn,
  input  logic             regWr,
  input  logic [3:0]       regAddr,
  input  logic [7:0]       regData,
  input  logic             outReady,
  output dpCtrl_t          ctl,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             dumping,
  output logic             outValid,
  output logic [7:0]       statusByte
);
  localparam logic [PTR_W:0]   FULL_CNT = (PTR_W+1)'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  capState_e        state;
  logic [PTR_W:0]   fillCnt;
  logic [PTR_W-1:0] sentCnt;
  logic [1:0]       byteIdx;
  logic             statusPend, forcePend, ctrlBit3;
  logic             fire, full, endCapture, forcePulse;
  logic             isStatusWr, isDumpWr, isCtrlWr;

  assign isStatusWr = regWr && regAddr == ADDR_STATUS;
  assign isDumpWr   = regWr && regAddr == ADDR_BUFFER;
  assign isCtrlWr   = regWr && regAddr == ADDR_CTRL;
  assign forcePulse = isCtrlWr && !regData[FORCE_BIT] && ctrlBit3;
  assign full       = fillCnt == FULL_CNT;
  assign endCapture = state == ST_CAPTURE && full && (trigIn || forcePend);
  assign dumping    = state == ST_DUMP;
  assign outValid   = statusPend || dumping;
  assign fire       = outValid && outReady;

  assign ctl.memWr   = state == ST_CAPTURE && !endCapture && sampleValid;
  assign ctl.byteSel = byteIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_CAPTURE;
      fillCnt    <= '0;
      wrPtr      <= '0;
      rdPtr      <= '0;
      sentCnt    <= '0;
      byteIdx    <= '0;
      forcePend  <= 1'b0;
      ctrlBit3   <= 1'b0;
      statusPend <= 1'b0;
      statusByte <= '0;
    end else begin
      if (isCtrlWr) ctrlBit3 <= regData[FORCE_BIT];

      case (state)
        ST_CAPTURE: begin
          if (endCapture) begin
            state     <= ST_READY;
            forcePend <= 1'b0;
          end else begin
            if (forcePulse) forcePend <= 1'b1;
            if (sampleValid) begin
              wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
              if (!full) fillCnt <= fillCnt + 1'b1;
            end
          end
        end
        ST_READY: begin
          if (isDumpWr && !statusPend) begin
            state   <= ST_DUMP;
            rdPtr   <= wrPtr;
            byteIdx <= '0;
            sentCnt <= '0;
          end
        end
        default: begin
          if (fire) begin
            if (byteIdx == 2'd2) begin
              byteIdx <= '0;
              rdPtr   <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
              if (sentCnt == LAST_IDX) begin
                state   <= ST_CAPTURE;
                fillCnt <= '0;
              end else begin
                sentCnt <= sentCnt + 1'b1;
              end
            end else begin
              byteIdx <= byteIdx + 1'b1;
            end
          end
        end
      endcase

      if (isStatusWr && state != ST_DUMP && !statusPend) begin
        statusPend <= 1'b1;
        statusByte <= (state == ST_READY) ? STAT_READY :
                      (full ? STAT_WAITING : STAT_FILLING);
      end else if (fire && state != ST_DUMP) begin
        statusPend <= 1'b0;
      end
    end
  end

  // R3: data-ready is only ever reached with a full window
  p_ready_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_READY |-> full);

  // R6: a dump is entered only from the data-ready state
  p_dump_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DUMP && $past(state) != ST_DUMP) |-> $past(state) == ST_READY);

  // R5: a status byte never competes with dump bytes
  p_status_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(statusPend && state == ST_DUMP));

  // R10: a stalled byte keeps its position and value
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(rdPtr) && $stable(byteIdx)
                                 && $stable(statusByte)));

  // R7: byte slot index stays within a sample
  p_slot_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byteIdx != 2'd3);
endmodule

// File: rtl/capture_dumper.sv
module capture_dumper
  import cbd_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sampleValid,
  input  logic [9:0]  analogIn,
  input  logic [7:0]  logicIn,
  input  logic        trigIn,
  input  logic        regWr,
  input  logic [3:0]  regAddr,
  input  logic [7:0]  regData,
  output logic        outValid,
  output logic [7:0]  outData,
  input  logic        outReady
);
  localparam int PTR_W = $clog2(DEPTH);

  dpCtrl_t          ctl;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             dumping;
  logic [7:0]       statusByte, dumpByte;

  cbd_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleValid(sampleValid),
    .trigIn     (trigIn),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regData    (regData),
    .outReady   (outReady),
    .ctl        (ctl),
    .wrPtr      (wrPtr),
    .rdPtr      (rdPtr),
    .dumping    (dumping),
    .outValid   (outValid),
    .statusByte (statusByte)
  );

  cbd_datapath #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_dp (
    .clk     (clk),
    .ctl     (ctl),
    .wrAddr  (wrPtr),
    .rdAddr  (rdPtr),
    .analogIn(analogIn),
    .logicIn (logicIn),
    .dumpByte(dumpByte)
  );

  assign outData = dumping ? dumpByte : statusByte;

  // R8: the two top bits of any offered byte are zero
  p_top_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outData[7:6] == 2'b00);
endmodule

// File: tb/test_capture_dumper.sv
module test_capture_dumper;
  localparam int CLK_P = 10;
  localparam int DEPTH = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sampleValid = 1'b0;
  logic [9:0] analogIn = '0;
  logic [7:0] logicIn = '0;
  logic       trigIn = 1'b0;
  logic       regWr = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regData = '0;
  logic       outValid;
  logic [7:0] outData;
  logic       outReady = 1'b1;

  int    checks = 0, fails = 0, cyc = 0, sIdx = 0, readyMode = 0, accCnt = 0;
  bit    countAcc = 0, finished = 0;
  string phaseTag = "R1";

  // behavioural reference
  int mState = 0, mFill = 0, mStat = 0;
  bit mPend = 0, mC3 = 0, mForce = 0;
  int hist[$];
  int dumpQ[$];

  capture_dumper #(.DEPTH(DEPTH)) i_capture_dumper (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .analogIn(analogIn),
    .logicIn(logicIn), .trigIn(trigIn), .regWr(regWr), .regAddr(regAddr),
    .regData(regData), .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic bit expValid();
    return mPend || mState == 2;
  endfunction

  function automatic int expData();
    if (mPend) return mStat;
    return (dumpQ.size() > 0) ? dumpQ[0] : 0;
  endfunction

  always @(posedge clk) begin
    bit fire, stq, dq, cq, pulse;
    int oldState, oldFill, a, l;
    bit oldPend;
    if (!rst_n) begin
      mState = 0; mFill = 0; mPend = 0; mC3 = 0; mForce = 0; mStat = 0;
      hist.delete(); dumpQ.delete();
    end else begin
      fire = expValid() && outReady;
      oldState = mState; oldFill = mFill; oldPend = mPend;
      stq = regWr && regAddr == 4'h1;
      dq  = regWr && regAddr == 4'h2;
      cq  = regWr && regAddr == 4'h4;
      pulse = cq && !regData[3] && mC3;
      if (cq) mC3 = regData[3];
      if (oldState == 0) begin
        if (oldFill == DEPTH && (trigIn || mForce)) begin
          mState = 1; mForce = 0;
        end else begin
          if (pulse) mForce = 1;
          if (sampleValid) begin
            hist.push_back({logicIn, analogIn});
            if (hist.size() > DEPTH) void'(hist.pop_front());
            if (mFill < DEPTH) mFill++;
          end
        end
      end else if (oldState == 1) begin
        if (dq && !oldPend) begin
          dumpQ.delete();
          foreach (hist[k]) begin
            a = hist[k] & 32'h3ff;
            l = (hist[k] >> 10) & 32'hff;
            dumpQ.push_back(a & 32'h3f);
            dumpQ.push_back(((l & 3) << 4) | (a >> 6));
            dumpQ.push_back(l >> 2);
          end
          mState = 2;
        end
      end else if (fire) begin
        void'(dumpQ.pop_front());
        if (dumpQ.size() == 0) begin mState = 0; mFill = 0; end
      end
      if (stq && oldState != 2 && !oldPend) begin
        mPend = 1;
        mStat = (oldState == 1) ? 5 : ((oldFill == DEPTH) ? 2 : 1);
      end else if (fire && oldState != 2) begin
        mPend = 0;
      end
    end
  end

  // compare the ports with the reference every cycle, away from the edge
  initial forever begin
    @(posedge clk);
    #(CLK_P/4);
    if (rst_n && !finished) begin
      checks++;
      if (outValid !== expValid()) begin
        fails++;
        $display("FAIL %s: outValid=%0b expected %0b at cycle %0d", phaseTag, outValid, expValid(), cyc);
      end
      if (expValid()) begin
        checks++;
        if (outData !== 8'(expData())) begin
          fails++;
          $display("FAIL %s: outData=0x%02h expected 0x%02h at cycle %0d",
                   mPend ? "R5" : "R7/R9", outData, 8'(expData()), cyc);
        end
      end
      if (outValid === 1'b1) begin
        checks++;
        if (outData[7:6] !== 2'b00) begin
          fails++;
          $display("FAIL R8: outData=0x%02h expected top bits 00", outData);
        end
      end
      if (countAcc && outValid && outReady) accCnt++;
    end
  end

  always @(negedge clk) begin
    cyc++;
    outReady <= (readyMode == 0) ? 1'b1 : (cyc % 3 != 0);
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, cycle %0d expected < 150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic feed(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      analogIn = 10'((sIdx * 37 + 5) & 32'h3ff);
      logicIn  = 8'((sIdx * 13 + (sIdx >> 2)) & 32'hff);
      sIdx++;
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk);
        sampleValid = 1'b0;
      end
    end
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic checkDumpCount(input string tag);
    checks++;
    if (accCnt != 3 * DEPTH) begin
      fails++;
      $display("FAIL %s: dump bytes=%0d expected %0d", tag, accCnt, 3 * DEPTH);
    end
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    phaseTag = "R1";                // reset state and first status query
    idle(2);
    wrReg(4'h1, 8'h00);
    idle(3);

    phaseTag = "R3";                // early trigger has no effect
    feed(100, 1);
    @(negedge clk) trigIn = 1'b1;
    idle(4);
    @(negedge clk) trigIn = 1'b0;
    phaseTag = "R6";                // dump request while filling ignored
    wrReg(4'h2, 8'h00);
    idle(4);

    phaseTag = "R2";                // fill past the window size
    feed(DEPTH + 50, 1);
    wrReg(4'h1, 8'h00);
    idle(3);

    phaseTag = "R3";                // trigger ends capture, later samples dropped
    @(negedge clk) trigIn = 1'b1;
    @(negedge clk) trigIn = 1'b0;
    feed(20, 0);
    wrReg(4'h1, 8'h00);
    idle(3);

    phaseTag = "R10";               // stalled dump, status query ignored mid-dump
    readyMode = 1;
    accCnt = 0; countAcc = 1;
    wrReg(4'h2, 8'h00);
    idle(30);
    phaseTag = "R5";
    wrReg(4'h1, 8'h00);
    phaseTag = "R10";
    while (mState != 0) @(negedge clk);
    idle(2);
    countAcc = 0;
    checkDumpCount("R6");
    readyMode = 0;
    wrReg(4'h1, 8'h00);
    idle(3);

    phaseTag = "R4";                // forced capture requested before full
    feed(200, 0);
    wrReg(4'h4, 8'h08);
    wrReg(4'h4, 8'h00);
    feed(DEPTH, 1);
    idle(3);
    wrReg(4'h1, 8'h00);
    idle(3);

    phaseTag = "R9";                // full-speed dump
    accCnt = 0; countAcc = 1;
    wrReg(4'h2, 8'h00);
    while (mState != 0) @(negedge clk);
    idle(2);
    countAcc = 0;
    checkDumpCount("R9");
    idle(4);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule